// File: doc/BRIEF.md
# SIMD Element-Pair Transpose Unit

This unit takes two vector operands, a first (destination) vector and a second vector, and treats them as a row of 2x2 element matrices. It transposes every matrix: in each adjacent element pair, the odd element of the first vector and the even element of the second vector trade places. The element size is 8, 16 or 32 bits. The operand width is 64 or 128 bits. Both are decoded at run time from a 32-bit instruction word that comes with the operands.

The decoder checks the fixed opcode bits, which come in two accepted forms, and extracts the size field, the width bit and both register numbers. It flags encodings that are illegal. It also flags the case where both operands name the same register. In either case the operands are returned unchanged. All results are registered, so each accepted input produces one valid output one clock later. The register file, condition checks, trap logic and hazard handling belong to the surrounding pipeline.

Top module: `trn_unit`

## Requirements
- R1: An instruction is legal only if bits [31:23] are 111100111 or 111111111, [21:20]=11, [17:16]=10, [11:7]=00001 and bit 4=0; any other fixed-bit value sets `undef_o`.
- R2: Bits [19:18] select the element size: 00 gives 8 bits, 01 gives 16 bits and 10 gives 32 bits; 11 is reserved and sets `undef_o`.
- R3: For every pair index e, element 2e+1 of `res_a` equals element 2e of the original `op_b`, and element 2e of `res_a` equals element 2e of `op_a`.
- R4: For every pair index e, element 2e of `res_b` equals element 2e+1 of the original `op_a`, and element 2e+1 of `res_b` equals element 2e+1 of `op_b`.
- R5: Bit 6 selects the width. When it is 0, only bits [63:0] are transposed and bits [127:64] of both results copy the operands. When it is 1, each 64-bit half is transposed independently.
- R6: When bit 6 is 1 and bit 12 or bit 0 is 1 (the low bits of the register numbers), `undef_o` is set.
- R7: For a legal encoding whose register numbers {bit22,[15:12]} and {bit5,[3:0]} are equal, `alias_o` is set and both results equal the operands unchanged.
- R8: When `undef_o` is set, `alias_o` is 0 and both results equal the operands unchanged.
- R9: `out_valid` follows `in_valid` with exactly one cycle of latency, and a synchronous reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction present |
| insn | input | 32 | Instruction word |
| op_a | input | 128 | First (destination) operand |
| op_b | input | 128 | Second operand |
| out_valid | output | 1 | Results present |
| res_a | output | 128 | Rewritten first vector |
| res_b | output | 128 | Rewritten second vector |
| undef_o | output | 1 | Illegal encoding |
| alias_o | output | 1 | Both register numbers equal |

## Verification
Some properties are checked on every cycle:
- the one-cycle valid latency and its clearing;
- that a rejected encoding returns the operands unchanged;
- that the upper half passes through in 64-bit mode;
- that the two flags never rise together;
- that inside each lane the lowest element of the first vector and the highest element of the second vector are never touched.

The actual cross-register element movement for each size and width can only be shown by the bench's scenarios. These sweep both opcode forms, all size codes, both widths and several data patterns against an arithmetic permutation model. Directed cases cover corrupted fixed bits, odd register numbers and aliasing.

// File: rtl/trn_pkg.sv
package trn_pkg;
  typedef enum logic [1:0] {
    ES_8   = 2'b00,
    ES_16  = 2'b01,
    ES_32  = 2'b10,
    ES_RSV = 2'b11
  } esize_t;

  localparam int INSN_W = 32;
  localparam logic [8:0] OPC_HI_A = 9'b111100111;
  localparam logic [8:0] OPC_HI_B = 9'b111111111;
endpackage

// File: rtl/trn_decode.sv
module trn_decode
  import trn_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output esize_t            size,
  output logic              wide,
  output logic              undef,
  output logic              alias_hit
);
  logic [4:0] rd_num, rm_num;
  logic       form_ok, fixed_ok;

  always_comb begin
    size     = esize_t'(insn[19:18]);
    wide     = insn[6];
    rd_num   = {insn[22], insn[15:12]};
    rm_num   = {insn[5], insn[3:0]};
    form_ok  = (insn[31:23] == OPC_HI_A) || (insn[31:23] == OPC_HI_B);
    fixed_ok = form_ok && (insn[21:20] == 2'b11) && (insn[17:16] == 2'b10)
               && (insn[11:7] == 5'b00001) && !insn[4];
    undef    = !fixed_ok || (size == ES_RSV) || (wide && (rd_num[0] || rm_num[0]));
    alias_hit = !undef && (rd_num == rm_num);
  end
endmodule

// File: rtl/trn_lane.sv
module trn_lane
  import trn_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  esize_t            size,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] ra,
  output logic [LANE_W-1:0] rb
);
  for (genvar sz = 0; sz < 3; sz++) begin : g_sz
    localparam int ES = 8 << sz;
    localparam int NP = LANE_W / (2 * ES);
    logic [LANE_W-1:0] pa, pb;
    for (genvar e = 0; e < NP; e++) begin : g_pair
      assign pa[2*e*ES +: ES]     = a[2*e*ES +: ES];
      assign pa[(2*e+1)*ES +: ES] = b[2*e*ES +: ES];
      assign pb[2*e*ES +: ES]     = a[(2*e+1)*ES +: ES];
      assign pb[(2*e+1)*ES +: ES] = b[(2*e+1)*ES +: ES];
    end
  end

  always_comb begin
    unique case (size)
      ES_8:    begin ra = g_sz[0].pa; rb = g_sz[0].pb; end
      ES_16:   begin ra = g_sz[1].pa; rb = g_sz[1].pb; end
      ES_32:   begin ra = g_sz[2].pa; rb = g_sz[2].pb; end
      default: begin ra = a;          rb = b;          end
    endcase
  end

  // R3
  always_comb begin
    lo_keep_chk: assert (ra[7:0] == a[7:0]);
  end

  // R4
  always_comb begin
    hi_keep_chk: assert (rb[LANE_W-1 -: 8] == b[LANE_W-1 -: 8]);
  end
endmodule

// File: rtl/trn_unit.sv
module trn_unit
  import trn_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int HALF_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] res_a,
  output logic [VEC_W-1:0] res_b,
  output logic             undef_o,
  output logic             alias_o
);
  localparam int NH = VEC_W / HALF_W;

  esize_t           dec_size;
  logic             dec_wide, dec_undef, dec_alias;
  logic [VEC_W-1:0] lane_a, lane_b, nxt_a, nxt_b;

  trn_decode u_dec (
    .insn      (insn),
    .size      (dec_size),
    .wide      (dec_wide),
    .undef     (dec_undef),
    .alias_hit (dec_alias)
  );

  for (genvar h = 0; h < NH; h++) begin : g_half
    trn_lane #(.LANE_W(HALF_W)) u_lane (
      .size (dec_size),
      .a    (op_a[h*HALF_W +: HALF_W]),
      .b    (op_b[h*HALF_W +: HALF_W]),
      .ra   (lane_a[h*HALF_W +: HALF_W]),
      .rb   (lane_b[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    if (dec_undef || dec_alias) begin
      nxt_a = op_a;
      nxt_b = op_b;
    end else if (dec_wide) begin
      nxt_a = lane_a;
      nxt_b = lane_b;
    end else begin
      nxt_a = op_a;
      nxt_b = op_b;
      nxt_a[HALF_W-1:0] = lane_a[HALF_W-1:0];
      nxt_b[HALF_W-1:0] = lane_b[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_a   <= nxt_a;
      res_b   <= nxt_b;
      undef_o <= dec_undef;
      alias_o <= dec_alias;
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_undef) |=> (undef_o && !alias_o &&
      res_a == $past(op_a) && res_b == $past(op_b)));

  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec_wide) |=>
      (res_a[VEC_W-1:HALF_W] == $past(op_a[VEC_W-1:HALF_W]) &&
       res_b[VEC_W-1:HALF_W] == $past(op_b[VEC_W-1:HALF_W])));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(undef_o && alias_o));
endmodule

// File: tb/test_trn_unit.sv
`timescale 1ns/1ps
module test_trn_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] op_a = '0, op_b = '0;
  logic         out_valid, undef_o, alias_o;
  logic [127:0] res_a, res_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trn_unit i_trn_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .res_a(res_a), .res_b(res_b), .undef_o(undef_o), .alias_o(alias_o)
  );

  function automatic logic [31:0] mk(bit form, logic [1:0] sz, logic [4:0] rd,
                                     bit q, logic [4:0] rm);
    logic [8:0] hi = form ? 9'b111111111 : 9'b111100111;
    return {hi, rd[4], 2'b11, sz, 2'b10, rd[3:0], 5'b00001, q, rm[4], 1'b0, rm[3:0]};
  endfunction

  task automatic model(input logic [127:0] a, input logic [127:0] b,
                       input int sz, input bit q,
                       output logic [127:0] ea, output logic [127:0] eb);
    int es = 8 << sz;
    int nh = q ? 2 : 1;
    ea = a; eb = b;
    for (int h = 0; h < nh; h++)
      for (int e = 0; e < 64 / (2 * es); e++)
        for (int k = 0; k < es; k++) begin
          ea[h*64 + (2*e+1)*es + k] = b[h*64 + 2*e*es + k];
          eb[h*64 + 2*e*es + k]     = a[h*64 + (2*e+1)*es + k];
        end
  endtask

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [127:0] a,
                     input logic [127:0] b, input bit e_undef, input bit e_alias,
                     input logic [127:0] ea, input logic [127:0] eb, input string req);
    @(negedge clk);
    insn = w; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
    chk({req, " undef"}, {127'd0, undef_o}, {127'd0, e_undef});
    chk({req, " alias"}, {127'd0, alias_o}, {127'd0, e_alias});
    chk({req, " res_a"}, res_a, ea);
    chk({req, " res_b"}, res_b, eb);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, ea, eb;
    logic [63:0]  s = 64'h9E3779B97F4A7C15;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;

    // R2 R3 R4 R5: sweep forms, size codes, widths, data patterns
    for (int f = 0; f < 2; f++)
      for (int sz = 0; sz < 4; sz++)
        for (int q = 0; q < 2; q++)
          for (int p = 0; p < 4; p++) begin
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); a[63:0] = s;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); a[127:64] = s;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); b[63:0] = s;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); b[127:64] = s;
            if (p == 0) begin a = {16{8'hA5}}; b = {16{8'h3C}}; end
            if (sz == 3) begin ea = a; eb = b; end
            else model(a, b, sz, q[0], ea, eb);
            run(mk(f[0], sz[1:0], 5'd2, q[0], 5'd4), a, b, sz == 3, 1'b0, ea, eb,
                sz == 3 ? "R2 rsv" : (q ? "R3 R4 R5 wide" : "R3 R4 R5 narrow"));
          end

    a = {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444};
    b = {32'h55555555, 32'h66666666, 32'h77777777, 32'h88888888};
    // R1 corrupted fixed bits: bit 4, bit 16, top bits
    run(mk(1'b0, 2'd0, 5'd2, 1'b1, 5'd4) | 32'h10, a, b, 1, 0, a, b, "R1 bit4");
    run(mk(1'b0, 2'd0, 5'd2, 1'b1, 5'd4) | 32'h10000, a, b, 1, 0, a, b, "R1 bit16");
    run(mk(1'b0, 2'd1, 5'd2, 1'b0, 5'd4) & ~32'h00800000, a, b, 1, 0, a, b, "R1 hi");
    // R6 odd register numbers in wide mode, R8 operands pass
    run(mk(1'b0, 2'd2, 5'd3, 1'b1, 5'd4), a, b, 1, 0, a, b, "R6 R8 rd odd");
    run(mk(1'b1, 2'd2, 5'd2, 1'b1, 5'd5), a, b, 1, 0, a, b, "R6 R8 rm odd");
    // R6 odd numbers allowed when narrow
    model(a, b, 2, 1'b0, ea, eb);
    run(mk(1'b0, 2'd2, 5'd3, 1'b0, 5'd5), a, b, 0, 0, ea, eb, "R6 narrow ok");
    // R7 aliasing, including top register bit
    run(mk(1'b0, 2'd0, 5'd6, 1'b1, 5'd6), a, b, 0, 1, a, b, "R7 alias");
    run(mk(1'b1, 2'd1, 5'd17, 1'b0, 5'd17), a, b, 0, 1, a, b, "R7 alias hi");
    model(a, b, 1, 1'b0, ea, eb);
    run(mk(1'b1, 2'd1, 5'd17, 1'b0, 5'd1), a, b, 0, 0, ea, eb, "R7 bit22 differs");

    // R9 valid drops one cycle after in_valid falls
    @(negedge clk);
    chk("R9 idle", {127'd0, out_valid}, 128'd0);
    @(negedge clk); insn = mk(1'b0, 2'd0, 5'd2, 1'b0, 5'd4); in_valid = 1'b1;
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 sync reset", {127'd0, out_valid}, 128'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule